// File: doc/BRIEF.md
# Network Link Status Indicator

This block converts per-cycle network events into five active-low indicator lines, each able to drive an LED directly. It takes a one-clock cycle-start strobe, two flags that are sampled on that strobe (master data present, link established), two event pulses (soft warning, hard alarm), a 2-bit bit-rate strap and three fault conditions. It drives a monitor line, a warning line, an alarm line, a master-absent line and a cycle-start pulse. All millisecond timing comes from a clock enable that a prescaler derives from the system clock.

The warning and alarm lines have two jobs. In normal operation they give short flashes when their events fire, and also once after reset. When a fault is present they show a fixed pattern instead. A configuration error (conflicting address straps, or the invalid rate code) holds the alarm line lit. A switch-read fault makes the two lines blink in turn with the short period. An internal fault makes them blink in turn with the long period. Every input is a plain level or pulse, with no handshake.

Top module: `lnk_status_ind`

## Requirements
- R1: `master_absent` is high out of reset. It goes low on the clock after a cycle strobe on which `master_seen` is 1.
- R2: `master_absent` goes high on the clock after the MISS_LIMIT-th (default 16) consecutive cycle strobe without `master_seen`. It changes only on the clock after a cycle strobe.
- R3: `mon_n` is low only once RUN_LIMIT (default 3) consecutive cycle strobes have had `link_up` = 1. A strobe with `link_up` = 0 drives `mon_n` high on the next clock.
- R4: A pulse on `warn_evt` (or `alarm_evt`) drives `warn_n` (or `alarm_n`) low from the next clock until FLASH_MS millisecond enables have passed. Both lines also flash this way right after reset is released.
- R5: An event that arrives while its flash is running restarts the flash with its full length.
- R6: Each cycle strobe drives `cyc_pulse_n` low for 2 × BIT_CLKS system clocks, starting on the next clock. BIT_CLKS is BIT_CLKS_FAST for `rate_sel` 00 (12 Mbps), BIT_CLKS_MID for 01 (6 Mbps) and BIT_CLKS_SLOW for 10 (3 Mbps).
- R7: `rate_sel` = 11 is a setting error. Cycle strobes then give no pulse, and `alarm_n` is held low for as long as the code is present. `strap_conflict` = 1 holds `alarm_n` low in the same way. In both cases `warn_n` keeps flashing on its own events.
- R8: While `sw_read_fault` = 1, `warn_n` and `alarm_n` are always opposite. `warn_n` is lit (low) first, and the pair swaps every BLINK_SHORT_MS millisecond enables.
- R9: While `core_fault` = 1 and `sw_read_fault` = 0, the pair alternates in the same way but swaps every BLINK_LONG_MS enables. If both faults are present, the short period applies.
- R10: A blink pattern overrides event flashes and the steady setting-error alarm. When all faults clear, the lines return at once to their flash and setting-error behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | One-clock strobe at the start of each network cycle |
| master_seen | input | 1 | Master data arrived this cycle (sampled on the strobe) |
| link_up | input | 1 | Link established this cycle (sampled on the strobe) |
| warn_evt | input | 1 | Soft link-loss event pulse |
| alarm_evt | input | 1 | Hard link-loss event pulse |
| rate_sel | input | 2 | Bit-rate strap: 00 fast, 01 mid, 10 slow, 11 invalid |
| strap_conflict | input | 1 | Own and master address straps collide |
| sw_read_fault | input | 1 | Switch-read hardware failure |
| core_fault | input | 1 | Internal hardware failure |
| mon_n | output | 1 | Low while the link is stable |
| warn_n | output | 1 | Warning indicator, active low |
| alarm_n | output | 1 | Alarm indicator, active low |
| master_absent | output | 1 | High while the master is not confirmed |
| cyc_pulse_n | output | 1 | Low pulse at each cycle start |

## Verification
A wrong miss or run count appears at `master_absent` or `mon_n` on the clock after the strobe that should have crossed the threshold. A flash or blink counter that is off by one moves an indicator edge by one millisecond enable, which with the bench's short prescaler is a few clocks. A wrong pulse-width load shows as a `cyc_pulse_n` edge at the wrong clock for that rate. The bench therefore compares all five outputs against a behavioural model on every clock, so any such slip is reported in the cycle where it first appears.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    RATE_FAST = 2'b00,
    RATE_MID  = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_BAD  = 2'b11
  } rate_e;

  typedef struct packed {
    logic alarm;
    logic warn;
  } ind_pair_t;
endpackage

// File: rtl/lnk_ms_timebase.sv
module lnk_ms_timebase #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign ms_tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (ms_tick) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/lnk_cycle_qual.sv
module lnk_cycle_qual #(
  parameter int MISS_LIMIT = 16,
  parameter int RUN_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  input  logic master_seen,
  input  logic link_up,
  output logic master_absent,
  output logic link_stable
);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam logic [MW-1:0] MISS_MAX = MW'(MISS_LIMIT);
  localparam logic [RW-1:0] RUN_MAX  = RW'(RUN_LIMIT);

  logic [MW-1:0] miss_q;
  logic [RW-1:0] run_q;
  logic          absent_q;
  logic [MW-1:0] miss_inc;

  assign miss_inc = (miss_q < MISS_MAX) ? miss_q + 1'b1 : miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q   <= '0;
      absent_q <= 1'b1;
    end else if (cycle_tick) begin
      if (master_seen) begin
        miss_q   <= '0;
        absent_q <= 1'b0;
      end else begin
        miss_q <= miss_inc;
        if (miss_inc >= MISS_MAX) absent_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (cycle_tick) begin
      if (!link_up)             run_q <= '0;
      else if (run_q < RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  assign master_absent = absent_q;
  assign link_stable   = (run_q >= RUN_MAX);

  AST_ABSENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && master_seen |=> !master_absent); // R1
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_tick |=> $stable(master_absent)); // R2
  AST_MON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && !link_up |=> !link_stable); // R3
endmodule

// File: rtl/lnk_cyc_pulse.sv
module lnk_cyc_pulse
  import lnk_pkg::*;
#(
  parameter int BIT_CLKS_FAST = 8,
  parameter int BIT_CLKS_MID  = 17,
  parameter int BIT_CLKS_SLOW = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_tick,
  input  logic [1:0] rate_sel,
  output logic       pulse_active
);
  localparam int CW = $clog2(2 * BIT_CLKS_SLOW + 1);

  rate_e         rate;
  logic [CW-1:0] load_val;
  logic          rate_ok;
  logic [CW-1:0] cnt_q;

  assign rate = rate_e'(rate_sel);

  always_comb begin
    rate_ok  = 1'b1;
    load_val = '0;
    case (rate)
      RATE_FAST: load_val = CW'(2 * BIT_CLKS_FAST);
      RATE_MID:  load_val = CW'(2 * BIT_CLKS_MID);
      RATE_SLOW: load_val = CW'(2 * BIT_CLKS_SLOW);
      default:   rate_ok  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (cycle_tick && rate_ok)  cnt_q <= load_val;
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_active = (cnt_q != '0);

  AST_CYC_START: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && (rate_sel != 2'b11) |=> pulse_active); // R6
  AST_CYC_BADRATE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && (rate_sel == 2'b11) && !pulse_active |=> !pulse_active); // R7
endmodule

// File: rtl/lnk_flash_timer.sv
module lnk_flash_timer #(
  parameter int FLASH_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic trigger,
  output logic active
);
  localparam int FW = $clog2(FLASH_MS + 1);
  localparam logic [FW-1:0] FULL = FW'(FLASH_MS);

  logic [FW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          left_q <= FULL;
    else if (trigger)                    left_q <= FULL;
    else if (ms_tick && left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

  AST_FLASH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> active); // R4
endmodule

// File: rtl/lnk_blink_gen.sv
module lnk_blink_gen #(
  parameter int BLINK_SHORT_MS = 1000,
  parameter int BLINK_LONG_MS  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic fast_fault,
  input  logic slow_fault,
  output logic blinking,
  output logic phase
);
  localparam int BW = $clog2(BLINK_LONG_MS + 1);
  localparam logic [BW-1:0] SHORT_LAST = BW'(BLINK_SHORT_MS - 1);
  localparam logic [BW-1:0] LONG_LAST  = BW'(BLINK_LONG_MS - 1);

  logic [BW-1:0] cnt_q;
  logic          phase_q;
  logic [BW-1:0] last;

  assign blinking = fast_fault | slow_fault;
  assign last     = fast_fault ? SHORT_LAST : LONG_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!blinking) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (ms_tick) begin
      if (cnt_q >= last) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase = phase_q;

  AST_BLINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !blinking |=> !phase); // R8
  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blinking && !ms_tick |=> $stable(phase)); // R9
endmodule

// File: rtl/lnk_status_ind.sv
module lnk_status_ind
  import lnk_pkg::*;
#(
  parameter int TICK_DIV       = 100000,
  parameter int FLASH_MS       = 50,
  parameter int BLINK_SHORT_MS = 1000,
  parameter int BLINK_LONG_MS  = 2000,
  parameter int MISS_LIMIT     = 16,
  parameter int RUN_LIMIT      = 3,
  parameter int BIT_CLKS_FAST  = 8,
  parameter int BIT_CLKS_MID   = 17,
  parameter int BIT_CLKS_SLOW  = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_tick,
  input  logic       master_seen,
  input  logic       link_up,
  input  logic       warn_evt,
  input  logic       alarm_evt,
  input  logic [1:0] rate_sel,
  input  logic       strap_conflict,
  input  logic       sw_read_fault,
  input  logic       core_fault,
  output logic       mon_n,
  output logic       warn_n,
  output logic       alarm_n,
  output logic       master_absent,
  output logic       cyc_pulse_n
);
  localparam int NFLASH = 2;

  logic      ms_tick;
  logic      link_stable;
  logic      pulse_active;
  logic      blinking;
  logic      phase;
  logic      cfg_err;
  ind_pair_t trig;
  ind_pair_t flash;

  lnk_ms_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick)
  );

  lnk_cycle_qual #(.MISS_LIMIT(MISS_LIMIT), .RUN_LIMIT(RUN_LIMIT)) u_qual (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .master_seen(master_seen), .link_up(link_up),
    .master_absent(master_absent), .link_stable(link_stable)
  );

  lnk_cyc_pulse #(
    .BIT_CLKS_FAST(BIT_CLKS_FAST), .BIT_CLKS_MID(BIT_CLKS_MID),
    .BIT_CLKS_SLOW(BIT_CLKS_SLOW)
  ) u_cyc (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .rate_sel(rate_sel), .pulse_active(pulse_active)
  );

  assign trig.warn  = warn_evt;
  assign trig.alarm = alarm_evt;

  logic [NFLASH-1:0] trig_v;
  logic [NFLASH-1:0] flash_v;
  assign trig_v = trig;
  assign flash  = flash_v;

  for (genvar g = 0; g < NFLASH; g++) begin : g_flash
    lnk_flash_timer #(.FLASH_MS(FLASH_MS)) u_flash (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
      .trigger(trig_v[g]), .active(flash_v[g])
    );
  end

  lnk_blink_gen #(
    .BLINK_SHORT_MS(BLINK_SHORT_MS), .BLINK_LONG_MS(BLINK_LONG_MS)
  ) u_blink (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .fast_fault(sw_read_fault), .slow_fault(core_fault),
    .blinking(blinking), .phase(phase)
  );

  assign cfg_err = strap_conflict | (rate_e'(rate_sel) == RATE_BAD);

  always_comb begin
    if (blinking) begin
      warn_n  = phase;
      alarm_n = ~phase;
    end else begin
      warn_n  = ~flash.warn;
      alarm_n = cfg_err ? 1'b0 : ~flash.alarm;
    end
  end

  assign mon_n       = ~link_stable;
  assign cyc_pulse_n = ~pulse_active;

  AST_MON_RESET_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_tick && !link_up |=> mon_n); // R3
  AST_STEADY_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_read_fault && !core_fault && strap_conflict |-> !alarm_n); // R7
  AST_BLINK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_read_fault && $stable(sw_read_fault) |-> (warn_n != alarm_n)); // R10
endmodule

// File: tb/lnk_status_ind_test.sv
module lnk_status_ind_test;
  localparam int DIV    = 4;
  localparam int FLASH  = 5;
  localparam int SHORT  = 8;
  localparam int LONG   = 16;
  localparam int MISS   = 16;
  localparam int RUN    = 3;
  localparam int BFAST  = 8;
  localparam int BMID   = 17;
  localparam int BSLOW  = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_tick = 0, master_seen = 0, link_up = 0;
  logic warn_evt = 0, alarm_evt = 0;
  logic [1:0] rate_sel = 2'b00;
  logic strap_conflict = 0, sw_read_fault = 0, core_fault = 0;
  logic mon_n, warn_n, alarm_n, master_absent, cyc_pulse_n;

  int tests = 0;
  int fails = 0;
  int clocks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lnk_status_ind #(
    .TICK_DIV(DIV), .FLASH_MS(FLASH), .BLINK_SHORT_MS(SHORT),
    .BLINK_LONG_MS(LONG), .MISS_LIMIT(MISS), .RUN_LIMIT(RUN),
    .BIT_CLKS_FAST(BFAST), .BIT_CLKS_MID(BMID), .BIT_CLKS_SLOW(BSLOW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .master_seen(master_seen), .link_up(link_up),
    .warn_evt(warn_evt), .alarm_evt(alarm_evt), .rate_sel(rate_sel),
    .strap_conflict(strap_conflict), .sw_read_fault(sw_read_fault),
    .core_fault(core_fault), .mon_n(mon_n), .warn_n(warn_n),
    .alarm_n(alarm_n), .master_absent(master_absent),
    .cyc_pulse_n(cyc_pulse_n)
  );

  // behavioural reference state
  int  m_pre = 0, m_fw = FLASH, m_fa = FLASH, m_miss = 0, m_run = 0;
  int  m_cyc = 0, m_bc = 0;
  bit  m_abs = 1, m_ph = 0;

  function automatic int half_bits(logic [1:0] r);
    if (r == 2'b00) return 2 * BFAST;
    if (r == 2'b01) return 2 * BMID;
    return 2 * BSLOW;
  endfunction

  always @(posedge clk) begin
    bit tick;
    int lim;
    if (!rst_n) begin
      m_pre = 0; m_fw = FLASH; m_fa = FLASH; m_miss = 0; m_run = 0;
      m_cyc = 0; m_bc = 0; m_abs = 1; m_ph = 0;
    end else begin
      tick  = (m_pre == DIV - 1);
      m_pre = tick ? 0 : m_pre + 1;
      if (warn_evt) m_fw = FLASH; else if (tick && m_fw > 0) m_fw = m_fw - 1;
      if (alarm_evt) m_fa = FLASH; else if (tick && m_fa > 0) m_fa = m_fa - 1;
      if (cycle_tick) begin
        if (master_seen) begin m_miss = 0; m_abs = 0; end
        else begin
          if (m_miss < MISS) m_miss = m_miss + 1;
          if (m_miss >= MISS) m_abs = 1;
        end
        if (!link_up) m_run = 0; else if (m_run < RUN) m_run = m_run + 1;
      end
      if (cycle_tick && rate_sel != 2'b11) m_cyc = half_bits(rate_sel);
      else if (m_cyc > 0) m_cyc = m_cyc - 1;
      if (!(sw_read_fault || core_fault)) begin m_bc = 0; m_ph = 0; end
      else if (tick) begin
        lim = sw_read_fault ? SHORT : LONG;
        if (m_bc >= lim - 1) begin m_bc = 0; m_ph = !m_ph; end
        else m_bc = m_bc + 1;
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic ew, ea;
    #2;
    if (rst_n && !done) begin
      if (sw_read_fault || core_fault) begin
        ew = m_ph; ea = !m_ph;
      end else begin
        ew = !(m_fw > 0);
        ea = (strap_conflict || rate_sel == 2'b11) ? 1'b0 : !(m_fa > 0);
      end
      check("R1 R2 master_absent", master_absent, m_abs);
      check("R3 mon_n", mon_n, !(m_run >= RUN));
      check("R6 R7 cyc_pulse_n", cyc_pulse_n, !(m_cyc > 0));
      check("R4 R5 R7 R8 R9 R10 warn_n", warn_n, ew);
      check("R4 R5 R7 R8 R9 R10 alarm_n", alarm_n, ea);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    clocks++;
    if (clocks > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d clocks", clocks);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic net_cycle(bit m, bit l, int gap);
    cycle_tick = 1; master_seen = m; link_up = l;
    @(negedge clk);
    cycle_tick = 0; master_seen = 0; link_up = 0;
    idle(gap);
  endtask

  task automatic pulse_warn();
    warn_evt = 1; @(negedge clk); warn_evt = 0;
  endtask

  task automatic pulse_alarm();
    alarm_evt = 1; @(negedge clk); alarm_evt = 0;
  endtask

  initial begin
    // reset state: absent high, both flash lines lit after release (R1 R4)
    idle(4);
    tests++;
    if (master_absent !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset master_absent actual %b expected 1", master_absent);
    end
    rst_n = 1;
    idle(30);

    // R1 R3 R6: master and link present at fast rate
    for (int i = 0; i < 5; i++) net_cycle(1, 1, 70);
    // R3: link drops for one strobe, then recovers
    net_cycle(1, 0, 20);
    for (int i = 0; i < 4; i++) net_cycle(1, 1, 5);
    // R2: master missing for 17 strobes, short gaps
    for (int i = 0; i < 17; i++) net_cycle(0, 1, 3);
    net_cycle(1, 1, 3);
    for (int i = 0; i < 15; i++) net_cycle(0, 1, 3);
    net_cycle(1, 1, 3);
    // R6: mid and slow rates, including retrigger inside a pulse
    rate_sel = 2'b01;
    net_cycle(1, 1, 40);
    net_cycle(1, 1, 10);
    net_cycle(1, 1, 40);
    rate_sel = 2'b10;
    net_cycle(1, 1, 80);
    // R7: invalid rate code, no pulse and steady alarm
    rate_sel = 2'b11;
    net_cycle(1, 1, 40);
    pulse_warn();
    idle(30);
    rate_sel = 2'b00;
    idle(10);

    // R4: single flashes
    pulse_warn(); idle(30);
    pulse_alarm(); idle(30);
    // R5: restart during active flash
    pulse_warn(); idle(12); pulse_warn(); idle(30);
    pulse_alarm(); idle(15); pulse_alarm(); idle(30);

    // R7: strap conflict holds alarm, warn still flashes
    strap_conflict = 1; idle(5); pulse_alarm(); pulse_warn(); idle(40);
    strap_conflict = 0; idle(10);

    // R8 R10: switch-read fault with events and conflict present
    sw_read_fault = 1; idle(20); pulse_warn(); pulse_alarm();
    strap_conflict = 1; idle(150);
    strap_conflict = 0; idle(20);
    // R9: add core fault (short wins), then core alone
    core_fault = 1; idle(80);
    sw_read_fault = 0; idle(200);
    // R10: clearing faults returns to flash behaviour
    pulse_warn();
    core_fault = 0; idle(40);
    // R9 alone from idle
    core_fault = 1; idle(300);
    core_fault = 0; idle(20);

    finish_run();
  end
endmodule